// File: doc/BRIEF.md
# Scan-Chain Register Access Port

This block is a 40-bit serial data register through which a debug host reaches a register bank over a scan chain. It uses three single-cycle strobes: capture, shift and update. On the update strobe the frame held in the register is decoded as a 32-bit data field, a 7-bit address and a direction flag.

A write frame produces one write cycle on the bank bus. A read frame produces one read cycle, and the word returned in that cycle is parked as the pending result. The next capture loads that result into the register, so every scan unloads the answer to the read made by the scan before it.

A host that drains a data port with a read side effect scans that port address N times. The host then finishes with one scan of a harmless address, such as an identification register, to collect the last word. The bank therefore sees exactly N side-effect reads.

The access sequencer has two states, and every transition is listed here:

| From | To | Taken when |
|---|---|---|
| `SEQ_IDLE` | `SEQ_IDLE` | No update strobe, or an update strobe for an unmapped address. |
| `SEQ_IDLE` | `SEQ_ACCESS` | An update strobe for a mapped address. |
| `SEQ_ACCESS` | `SEQ_IDLE` | Always, after one cycle. |

Top module: `scan_reg_port`

## Requirements
- R1: The register shifts toward bit 0 on each shift strobe. `tdi` enters bit 39 and `tdo` always shows bit 0, so a frame goes in least significant bit first with this layout: data in bits 31:0, address in bits 38:32, direction flag in bit 39.
- R2: A frame whose flag is 1 is a write. In the cycle after the update strobe it drives `bus_wr` for exactly one cycle, carrying the frame's address and data.
- R3: A frame whose flag is 0 is a read. In the cycle after the update strobe it drives `bus_rd` for exactly one cycle with the frame's address, and `bus_rdata` in that cycle becomes the pending result.
- R4: A capture strobe loads the pending result into bits 31:0 and zero into bits 39:32.
- R5: The data unloaded by a scan is the read result requested by the previous scan. After reset, or after a write frame, the pending result is zero.
- R6: An address at or above `NUM_REGS` has no register behind it. It causes no bus cycle, and a read of it leaves a pending result of zero.
- R7: `bus_rd` and `bus_wr` are never high together, and a bus cycle happens only in the cycle right after an update strobe.
- R8: Capture and shift strobes never cause a bus cycle, so a burst of N reads of a side-effect port followed by one read of another address gives exactly N side-effect reads and returns N consecutive words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dr_capture | input | 1 | Capture strobe: loads the pending result |
| dr_shift | input | 1 | Shift strobe: moves the register one bit |
| dr_update | input | 1 | Update strobe: decodes the frame and starts the access |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out (bit 0 of the register) |
| bus_rd | output | 1 | Bank read cycle |
| bus_wr | output | 1 | Bank write cycle |
| bus_addr | output | 7 | Bank address |
| bus_wdata | output | 32 | Bank write data |
| bus_rdata | input | 32 | Bank read data, valid in the cycle `bus_rd` is high |

## Verification
The bench builds the block with `NUM_REGS` set to 8. This leaves 120 of the 128 addresses unmapped, and all of them are swept with a write followed by a read. The bench attaches a bank model with a read-only identification word at address 0, a self-advancing data port at address 4 and a pointer-load register at address 5. This brings in reach the pipelined read, the burst with its trailing dummy read, and a pointer that must advance once per read.

// File: rtl/scan_reg_pkg.sv
package scan_reg_pkg;
    localparam int DATA_W = 32;
    localparam int ADDR_W = 7;
    localparam int FRAME_W = DATA_W + ADDR_W + 1;

    typedef struct packed {
        logic              is_wr;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } frame_t;

    typedef enum logic {
        SEQ_IDLE   = 1'b0,
        SEQ_ACCESS = 1'b1
    } seq_state_t;
endpackage

// File: rtl/scan_shifter.sv
module scan_shifter
    import scan_reg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_i,
    input  logic              shift_i,
    input  logic              tdi_i,
    input  logic [DATA_W-1:0] result_i,
    output frame_t            frame_o,
    output logic              tdo_o
);
    logic [FRAME_W-1:0] sr_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr_q <= '0;
        end else if (cap_i) begin
            sr_q <= {{(FRAME_W-DATA_W){1'b0}}, result_i};
        end else if (shift_i) begin
            sr_q <= {tdi_i, sr_q[FRAME_W-1:1]};
        end
    end

    assign frame_o = frame_t'(sr_q);
    assign tdo_o   = sr_q[0];
endmodule

// File: rtl/scan_access_seq.sv
module scan_access_seq
    import scan_reg_pkg::*;
#(
    parameter int NUM_REGS = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              update_i,
    input  frame_t            frame_i,
    input  logic [DATA_W-1:0] bus_rdata_i,
    output logic              bus_rd_o,
    output logic              bus_wr_o,
    output logic [ADDR_W-1:0] bus_addr_o,
    output logic [DATA_W-1:0] bus_wdata_o,
    output logic [DATA_W-1:0] result_o
);
    localparam int MAP_W = ADDR_W + 1;
    localparam logic [MAP_W-1:0] MAP_LIMIT = MAP_W'(NUM_REGS);

    seq_state_t state_q, state_d;
    frame_t     op_q;
    logic       mapped;

    assign mapped = {1'b0, frame_i.addr} < MAP_LIMIT;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SEQ_IDLE:   if (update_i && mapped) state_d = SEQ_ACCESS;
            SEQ_ACCESS: state_d = SEQ_IDLE;
            default:    state_d = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SEQ_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q     <= '0;
            result_o <= '0;
        end else begin
            if (update_i && state_q == SEQ_IDLE) begin
                op_q     <= frame_i;
                result_o <= '0;
            end else if (state_q == SEQ_ACCESS && !op_q.is_wr) begin
                result_o <= bus_rdata_i;
            end
        end
    end

    always_comb begin
        bus_rd_o    = 1'b0;
        bus_wr_o    = 1'b0;
        bus_addr_o  = op_q.addr;
        bus_wdata_o = op_q.data;
        unique case (state_q)
            SEQ_IDLE:   ;
            SEQ_ACCESS: begin
                bus_rd_o = !op_q.is_wr;
                bus_wr_o = op_q.is_wr;
            end
            default:    ;
        endcase
    end
endmodule

// File: rtl/scan_reg_port.sv
module scan_reg_port
    import scan_reg_pkg::*;
#(
    parameter int NUM_REGS = 32
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        dr_capture,
    input  logic        dr_shift,
    input  logic        dr_update,
    input  logic        tdi,
    output logic        tdo,
    output logic        bus_rd,
    output logic        bus_wr,
    output logic [6:0]  bus_addr,
    output logic [31:0] bus_wdata,
    input  logic [31:0] bus_rdata
);
    frame_t            frame;
    logic [DATA_W-1:0] result;

    scan_shifter u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .cap_i    (dr_capture),
        .shift_i  (dr_shift),
        .tdi_i    (tdi),
        .result_i (result),
        .frame_o  (frame),
        .tdo_o    (tdo)
    );

    scan_access_seq #(.NUM_REGS(NUM_REGS)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .update_i    (dr_update),
        .frame_i     (frame),
        .bus_rdata_i (bus_rdata),
        .bus_rd_o    (bus_rd),
        .bus_wr_o    (bus_wr),
        .bus_addr_o  (bus_addr),
        .bus_wdata_o (bus_wdata),
        .result_o    (result)
    );
endmodule

// File: rtl/scan_reg_port_chk.sv
module scan_reg_port_chk #(
    parameter int NUM_REGS = 32
) (
    input logic        clk,
    input logic        rst_n,
    input logic        dr_capture,
    input logic        dr_update,
    input logic        bus_rd,
    input logic        bus_wr,
    input logic [6:0]  bus_addr,
    input logic [39:0] frame
);
    AST_RD_WR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_rd && bus_wr)); // R7

    AST_BUS_AFTER_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd || bus_wr) |-> $past(dr_update)); // R7

    AST_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd || bus_wr) |=> !(bus_rd || bus_wr)); // R8

    AST_MAPPED_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd || bus_wr) |-> ({1'b0, bus_addr} < 8'(NUM_REGS))); // R6

    AST_CAPTURE_TOP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        dr_capture |=> (frame[39:32] == 8'h00)); // R4
endmodule

bind scan_reg_port scan_reg_port_chk #(.NUM_REGS(NUM_REGS)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .dr_capture (dr_capture),
    .dr_update  (dr_update),
    .bus_rd     (bus_rd),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .frame      (frame)
);

// File: tb/scan_reg_port_test.sv
module scan_reg_port_test;
    localparam int NREG = 8;
    localparam logic [31:0] ID_WORD = 32'h1D0C_0001;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic dr_capture = 1'b0, dr_shift = 1'b0, dr_update = 1'b0, tdi = 1'b0;
    logic tdo, bus_rd, bus_wr;
    logic [6:0]  bus_addr;
    logic [31:0] bus_wdata, bus_rdata;

    int total = 0, bad = 0;
    int rd_cnt = 0, wr_cnt = 0;

    always #10 clk = ~clk;

    scan_reg_port #(.NUM_REGS(NREG)) uut (
        .clk(clk), .rst_n(rst_n), .dr_capture(dr_capture), .dr_shift(dr_shift),
        .dr_update(dr_update), .tdi(tdi), .tdo(tdo), .bus_rd(bus_rd),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata)
    );

    // bank model
    logic [31:0] regs [NREG];
    logic [3:0]  ptr;

    function automatic logic [31:0] ram_word(input logic [3:0] i);
        return 32'hA500_0000 + 32'(i) * 32'h0000_0111;
    endfunction

    assign bus_rdata = (bus_addr == 7'd0) ? ID_WORD :
                       (bus_addr == 7'd4) ? ram_word(ptr) : regs[bus_addr[2:0]];

    always @(posedge clk) begin
        if (!rst_n) begin
            ptr <= '0;
            for (int i = 0; i < NREG; i++) regs[i] <= '0;
        end else begin
            if (bus_rd) rd_cnt <= rd_cnt + 1;
            if (bus_wr) wr_cnt <= wr_cnt + 1;
            if (bus_rd && bus_addr == 7'd4) ptr <= ptr + 4'd1;
            if (bus_wr) begin
                if (bus_addr == 7'd5) ptr <= bus_wdata[3:0];
                else if (bus_addr != 7'd0 && bus_addr != 7'd4) regs[bus_addr[2:0]] <= bus_wdata;
            end
        end
    end

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // one full scan; returns unloaded 40 bits and bus strobe counts
    task automatic scan(input logic wr, input logic [6:0] a, input logic [31:0] d,
                        output logic [39:0] got, output int nrd, output int nwr);
        logic [39:0] fr;
        int r0, w0;
        fr = {wr, a, d};
        r0 = rd_cnt; w0 = wr_cnt;
        @(negedge clk) dr_capture = 1'b1;
        @(negedge clk) dr_capture = 1'b0;
        for (int i = 0; i < 40; i++) begin
            dr_shift = 1'b1;
            tdi = fr[i];
            got[i] = tdo;
            @(negedge clk);
        end
        dr_shift = 1'b0;
        dr_update = 1'b1;
        @(negedge clk) dr_update = 1'b0;
        repeat (3) @(negedge clk);
        nrd = rd_cnt - r0;
        nwr = wr_cnt - w0;
    endtask

    initial begin
        #2_000_000;
        total++; bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [39:0] g, pt;
        int nr, nw;
        logic [31:0] prev;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset tdo", 64'(tdo), 64'd0);

        // R5: first scan after reset returns zero
        scan(1'b0, 7'd1, 32'h0, g, nr, nw);
        check("R5 after reset", 64'(g), 64'd0);
        check("R3 one read strobe", 64'(nr), 64'd1);

        // R1: pass-through without capture
        pt = 40'hC3_5A5A_1234;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk) dr_shift = 1'b1; tdi = pt[i];
        end
        for (int i = 0; i < 40; i++) begin
            @(negedge clk) tdi = 1'b0; g[i] = tdo;
        end
        @(negedge clk) dr_shift = 1'b0;
        check("R1 pass-through", 64'(g), 64'(pt));
        check("R8 no bus on shift", 64'(rd_cnt + wr_cnt), 64'd1);

        // R2: write mapped registers, each exactly one write cycle
        for (int a = 1; a < NREG; a++) begin
            if (a == 4 || a == 5) continue;
            scan(1'b1, 7'(a), 32'(a) * 32'h0101_0101 ^ 32'h0000_00C3, g, nr, nw);
            check("R2 write strobe", {32'(nr), 32'(nw)}, {32'd0, 32'd1});
        end
        // R5: scan after write returns zero
        scan(1'b0, 7'd0, 32'h0, g, nr, nw);
        check("R5 after write", 64'(g), 64'd0);

        // R3/R5: pipelined read sweep; previous was read of ID
        prev = ID_WORD;
        for (int a = 1; a < NREG; a++) begin
            if (a == 4 || a == 5) continue;
            scan(1'b0, 7'(a), 32'hFFFF_FFFF, g, nr, nw);
            check("R5 pipelined read", 64'(g), 64'(prev));
            check("R4 top bits zero", 64'(g[39:32]), 64'd0);
            prev = 32'(a) * 32'h0101_0101 ^ 32'h0000_00C3;
        end

        // R8: burst of 5 from pointer 3, trailing ID read
        scan(1'b1, 7'd5, 32'd3, g, nr, nw);
        for (int k = 0; k < 5; k++) begin
            scan(1'b0, 7'd4, 32'h0, g, nr, nw);
            check("R3 burst strobe", 64'(nr), 64'd1);
            if (k > 0) check("R8 burst word", 64'(g), 64'(ram_word(4'(2 + k))));
        end
        scan(1'b0, 7'd0, 32'h0, g, nr, nw);
        check("R8 last burst word", 64'(g), 64'(ram_word(4'd7)));
        scan(1'b0, 7'd4, 32'h0, g, nr, nw);
        check("R8 ID after burst", 64'(g), 64'(ID_WORD));
        scan(1'b0, 7'd0, 32'h0, g, nr, nw);
        check("R8 pointer advanced once per read", 64'(g), 64'(ram_word(4'd8)));

        // R6: unmapped sweep
        for (int a = NREG; a < 128; a++) begin
            scan(1'b1, 7'(a), 32'hDEAD_0000 | 32'(a), g, nr, nw);
            check("R6 write no bus", {32'(nr), 32'(nw)}, 64'd0);
            scan(1'b0, 7'(a), 32'h0, g, nr, nw);
            check("R6 read no bus", {32'(nr), 32'(nw)}, 64'd0);
            scan(1'b0, 7'(a), 32'h0, g, nr, nw);
            check("R6 reads zero", 64'(g), 64'd0);
        end
        // R6: mapped registers untouched by unmapped writes
        scan(1'b0, 7'd2, 32'h0, g, nr, nw);
        scan(1'b0, 7'd0, 32'h0, g, nr, nw);
        check("R6 bank intact", 64'(g), 64'(32'h0202_0202 ^ 32'h0000_00C3));

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule